// File: doc/BRIEF.md
# Programmable DRAM Strobe Sequencer

This block produces the row strobe, column strobe and write-enable waveforms for one closed-page access to a group of DRAM modules. Configuration inputs set the position of each strobe. Every strobe has its own first-low cycle and last-low cycle, counted from the first cycle of the access. The access length is not fixed by a state machine. It follows from the latest last-low cycle among the three strobes: the access ends in the cycle after that one. The block pulses a done flag in that cycle and then holds every strobe high for a programmable precharge interval. Only after that interval does it accept another request. Because of this, two accesses to the same module are always separated by a full precharge.

Requests arrive through a valid/ready handshake. Each request carries a write flag, a processor-origin flag, a 13-bit row, a 13-bit column and a module-group select. At acceptance, the block captures the request fields and the timing derived from the configuration. The shared address bus carries the row at first and switches to the column when the column strobe's first-low cycle arrives. A stretch input holds the cycle counter so the sequence can wait on surrounding logic. For reads issued by the processor, an optional fast timing moves the column strobe earlier by a programmed amount. The move is limited so that at least one cycle always separates the row strobe's first-low cycle from the column strobe's.

Top module: `dram_strobe_seq`

## Requirements
- R1: While reset is applied and until it has been released, req_ready is low. Once released, the block idles with req_ready high, every strobe high, mem_addr zero and cyc_done low.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. The clock period that follows this edge is access cycle 1, and the count rises by one each cycle. A strobe is low in every cycle k with first-low <= k <= last-low.
- R3: cyc_done is high for exactly one cycle, in cycle max(ras last-low, cas last-low, we last-low) + 1. All strobes are high in that cycle. For example, the row strobe in cycles 1..10 with the column strobe ending at 14 gives done in cycle 15.
- R4: After the done cycle, all strobes stay high and req_ready stays low for P cycles, where P is cfg_pre_len, and a value of 0 acts as 1. req_ready rises in the cycle after those P cycles. This precharge also applies between two accesses to the same module group.
- R5: During an access, mem_addr carries the row in cycles before the column strobe's effective first-low cycle, and the column from that cycle up to and including the done cycle. Outside an access, mem_addr is zero.
- R6: we_n goes low only for write requests (req_write = 1), in the programmed window. On a read it stays high throughout.
- R7: While stretch is high in an access cycle other than the done cycle, the cycle count does not advance, so all outputs repeat in the next cycle. stretch has no effect in the done cycle or during precharge.
- R8: When cfg_fast_en = 1 and the request is a read with req_cpu = 1, both column-strobe edges move earlier by min(cfg_fast_cut, cas first-low - ras first-low - 1), or by 0 when that gap is at most 1. The done cycle is recomputed from the moved edge. Writes and non-processor reads keep the programmed timing.
- R9: ras_n has one lane for each module group. Only lane req_sel goes low. cas_n and we_n are shared by all groups.
- R10: Configuration and request inputs are sampled only at acceptance. A req_valid held high while req_ready is low is not accepted, and neither it nor later changes to the inputs alter the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ras_on | input | 5 | Row strobe first-low cycle |
| cfg_ras_off | input | 5 | Row strobe last-low cycle |
| cfg_cas_on | input | 5 | Column strobe first-low cycle |
| cfg_cas_off | input | 5 | Column strobe last-low cycle |
| cfg_we_on | input | 5 | Write-enable first-low cycle |
| cfg_we_off | input | 5 | Write-enable last-low cycle |
| cfg_pre_len | input | 4 | Precharge length in cycles (0 acts as 1) |
| cfg_fast_en | input | 1 | Enables fast timing for processor reads |
| cfg_fast_cut | input | 5 | Cycles to pull the column strobe earlier in fast timing |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 1 | Request issued by the processor |
| req_row | input | 13 | Row address |
| req_col | input | 13 | Column address |
| req_sel | input | 2 | Module group select |
| stretch | input | 1 | Holds the access cycle count |
| mem_addr | output | 13 | Multiplexed row/column address |
| ras_n | output | 4 | Active-low row strobe, one per module group |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Active-low write enable |
| cyc_done | output | 1 | One-cycle pulse in the final cycle of an access |

## Verification
The sequencer is driven with plain reads and writes under the default edge placement, where the 15-cycle access checks the end rule against the latest last-low edge. Stretch bursts are placed early, mid-access and on the done cycle, which separates a frozen count from one that advances and checks that the done cycle cannot be held. Fast timing is applied with a small cut and with an oversize cut, which shows the one-cycle floor. It is also applied to processor writes and non-processor reads, which must keep normal timing. Further runs vary the module select and use precharge lengths of 0 and 15. One run changes every input and holds valid high in mid-access, to show that only the values captured at acceptance count.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_PRE  = 2'd2
  } phase_e;

  // strobe generator slots; order fixes the index into the edge arrays
  localparam int NSTB    = 3;
  localparam int STB_RAS = 0;
  localparam int STB_CAS = 1;
  localparam int STB_WE  = 2;

endpackage

// File: rtl/dseq_timing.sv
// Turns the programmed edges into the edges used for one access:
// applies the fast-path pull-in to the column strobe and derives the end cycle.
module dseq_timing
  import dseq_pkg::*;
#(
  parameter int EW = 5,
  parameter int CW = EW + 1
) (
  input  logic                     fast,
  input  logic [EW-1:0]            fast_cut,
  input  logic [EW-1:0]            ras_on,
  input  logic [EW-1:0]            ras_off,
  input  logic [EW-1:0]            cas_on,
  input  logic [EW-1:0]            cas_off,
  input  logic [EW-1:0]            we_on,
  input  logic [EW-1:0]            we_off,
  output logic [NSTB-1:0][EW-1:0]  on_eff,
  output logic [NSTB-1:0][EW-1:0]  off_eff,
  output logic [CW-1:0]            end_cnt
);

  logic [CW-1:0] gap;
  logic [CW-1:0] room;
  logic [CW-1:0] shift;
  logic [EW-1:0] cas_on_s;
  logic [EW-1:0] cas_off_s;
  logic [EW-1:0] last_a;
  logic [EW-1:0] last_b;

  always_comb begin
    gap = {1'b0, cas_on} - {1'b0, ras_on};
    // spacing may shrink to one cycle and no further
    if ((cas_on > ras_on) && (gap > CW'(1))) begin
      room = gap - CW'(1);
    end else begin
      room = '0;
    end

    if (!fast) begin
      shift = '0;
    end else if ({1'b0, fast_cut} < room) begin
      shift = {1'b0, fast_cut};
    end else begin
      shift = room;
    end

    cas_on_s = cas_on - shift[EW-1:0];
    if ({1'b0, cas_off} >= shift) begin
      cas_off_s = cas_off - shift[EW-1:0];
    end else begin
      cas_off_s = '0;
    end

    on_eff[STB_RAS]  = ras_on;
    off_eff[STB_RAS] = ras_off;
    on_eff[STB_CAS]  = cas_on_s;
    off_eff[STB_CAS] = cas_off_s;
    on_eff[STB_WE]   = we_on;
    off_eff[STB_WE]  = we_off;

    last_a  = (ras_off > cas_off_s) ? ras_off : cas_off_s;
    last_b  = (last_a > we_off) ? last_a : we_off;
    end_cnt = {1'b0, last_b} + CW'(1);
  end

endmodule

// File: rtl/dseq_ctrl.sv
// Phase and cycle counter: idle -> active (counts 1..end) -> precharge -> idle.
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int CW = 6,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          stretch,
  input  logic [CW-1:0] end_cnt,
  input  logic [PW-1:0] pre_len,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          done,
  output logic          idle
);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] pre_eff;
  logic          at_end;
  logic          step_en;

  always_comb begin
    pre_eff = (pre_len == '0) ? PW'(1) : pre_len;
    at_end  = (phase_q == PH_ACT) && (cnt_q == end_cnt);
    phase_d = phase_q;
    cnt_d   = cnt_q;
    pcnt_d  = pcnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_ACT;
          cnt_d   = CW'(1);
        end
      end
      PH_ACT: begin
        if (at_end) begin
          // done cycle is never held by stretch
          phase_d = PH_PRE;
          cnt_d   = '0;
          pcnt_d  = PW'(1);
        end else if (!stretch) begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_PRE: begin
        if (pcnt_q >= pre_eff) begin
          phase_d = PH_IDLE;
          pcnt_d  = '0;
        end else begin
          pcnt_d = pcnt_q + PW'(1);
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
        pcnt_d  = '0;
      end
    endcase
    step_en = (phase_d != phase_q) || (cnt_d != cnt_q) || (pcnt_d != pcnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pcnt_q  <= '0;
    end else if (step_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;
  assign done  = at_end;
  assign idle  = (phase_q == PH_IDLE);

endmodule

// File: rtl/dseq_strobe.sv
// One edge-placed strobe: low while first <= count <= last in the active phase.
module dseq_strobe #(
  parameter int EW = 5,
  parameter int CW = EW + 1
) (
  input  logic          active,
  input  logic          enable,
  input  logic [CW-1:0] cnt,
  input  logic [EW-1:0] on_cnt,
  input  logic [EW-1:0] off_cnt,
  output logic          strobe_n
);

  logic in_window;

  always_comb begin
    in_window = (cnt >= {1'b0, on_cnt}) && (cnt <= {1'b0, off_cnt});
    strobe_n  = !(active && enable && in_window);
  end

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dseq_pkg::*;
#(
  parameter int EW    = 5,
  parameter int AW    = 13,
  parameter int PW    = 4,
  parameter int NGRP  = 4,
  parameter int SEL_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EW-1:0]    cfg_ras_on,
  input  logic [EW-1:0]    cfg_ras_off,
  input  logic [EW-1:0]    cfg_cas_on,
  input  logic [EW-1:0]    cfg_cas_off,
  input  logic [EW-1:0]    cfg_we_on,
  input  logic [EW-1:0]    cfg_we_off,
  input  logic [PW-1:0]    cfg_pre_len,
  input  logic             cfg_fast_en,
  input  logic [EW-1:0]    cfg_fast_cut,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_cpu,
  input  logic [AW-1:0]    req_row,
  input  logic [AW-1:0]    req_col,
  input  logic [SEL_W-1:0] req_sel,
  input  logic             stretch,
  output logic [AW-1:0]    mem_addr,
  output logic [NGRP-1:0]  ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             cyc_done
);

  localparam int CW = EW + 1;

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  // ---------------- handshake ----------------
  logic idle;
  logic accept;
  assign req_ready = idle && rst_core_n;
  assign accept    = req_valid && req_ready;

  // ---------------- timing derived from live configuration ----------------
  logic                    fast_req;
  logic [NSTB-1:0][EW-1:0] on_calc;
  logic [NSTB-1:0][EW-1:0] off_calc;
  logic [CW-1:0]           end_calc;

  assign fast_req = cfg_fast_en && req_cpu && !req_write;

  dseq_timing #(.EW(EW), .CW(CW)) u_timing (
    .fast     (fast_req),
    .fast_cut (cfg_fast_cut),
    .ras_on   (cfg_ras_on),
    .ras_off  (cfg_ras_off),
    .cas_on   (cfg_cas_on),
    .cas_off  (cfg_cas_off),
    .we_on    (cfg_we_on),
    .we_off   (cfg_we_off),
    .on_eff   (on_calc),
    .off_eff  (off_calc),
    .end_cnt  (end_calc)
  );

  // ---------------- capture at acceptance ----------------
  logic [NSTB-1:0][EW-1:0] on_q;
  logic [NSTB-1:0][EW-1:0] off_q;
  logic [CW-1:0]           end_q;
  logic [PW-1:0]           pre_q;
  logic [AW-1:0]           row_q;
  logic [AW-1:0]           col_q;
  logic [SEL_W-1:0]        sel_q;
  logic                    wr_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      on_q  <= '0;
      off_q <= '0;
      end_q <= '0;
      pre_q <= '0;
      row_q <= '0;
      col_q <= '0;
      sel_q <= '0;
      wr_q  <= 1'b0;
    end else if (accept) begin
      on_q  <= on_calc;
      off_q <= off_calc;
      end_q <= end_calc;
      pre_q <= cfg_pre_len;
      row_q <= req_row;
      col_q <= req_col;
      sel_q <= req_sel;
      wr_q  <= req_write;
    end
  end

  // ---------------- phase / cycle counter ----------------
  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          done;
  logic          in_act;

  dseq_ctrl #(.CW(CW), .PW(PW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .accept  (accept),
    .stretch (stretch),
    .end_cnt (end_q),
    .pre_len (pre_q),
    .phase   (phase),
    .cnt     (cnt),
    .done    (done),
    .idle    (idle)
  );

  assign in_act   = (phase == PH_ACT);
  assign cyc_done = done;

  // ---------------- strobe generators ----------------
  logic [NSTB-1:0] stb_en;
  logic [NSTB-1:0] stb_n;

  always_comb begin
    stb_en          = '1;
    stb_en[STB_WE]  = wr_q;
  end

  for (genvar s = 0; s < NSTB; s++) begin : g_stb
    dseq_strobe #(.EW(EW), .CW(CW)) u_stb (
      .active   (in_act),
      .enable   (stb_en[s]),
      .cnt      (cnt),
      .on_cnt   (on_q[s]),
      .off_cnt  (off_q[s]),
      .strobe_n (stb_n[s])
    );
  end

  // row strobe steered to the selected module group
  for (genvar g = 0; g < NGRP; g++) begin : g_lane
    assign ras_n[g] = !(!stb_n[STB_RAS] && (sel_q == SEL_W'(g)));
  end

  assign cas_n = stb_n[STB_CAS];
  assign we_n  = stb_n[STB_WE];

  // ---------------- address multiplexer ----------------
  logic col_phase;

  always_comb begin
    col_phase = (cnt >= {1'b0, on_q[STB_CAS]});
    if (!in_act) begin
      mem_addr = '0;
    end else if (col_phase) begin
      mem_addr = col_q;
    end else begin
      mem_addr = row_q;
    end
  end

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int NGRP = 4,
  parameter int AW   = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            stretch,
  input logic            in_act,
  input logic            wr_q,
  input logic [NGRP-1:0] ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [AW-1:0]   mem_addr,
  input logic            cyc_done
);

  // R10: an accepted request closes the handshake in the next cycle
  a_r10_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: every strobe is high in the done cycle
  a_r3_done_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> ((&ras_n) && cas_n && we_n));

  // R3: done is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);

  // R4: precharge follows the done cycle, so no acceptance right after it
  a_r4_pre_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> (!req_ready && (&ras_n) && cas_n && we_n));

  // R4 / R5: an idle sequencer drives quiet strobes and a zero address
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&ras_n) && cas_n && we_n && (mem_addr == '0)));

  // R6: write enable only for a captured write
  a_r6_we_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> wr_q);

  // R9: at most one row strobe lane low
  a_r9_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ras_n));

  // R7: a stretched access cycle repeats its outputs
  a_r7_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch && in_act && !cyc_done) |=>
      ($stable(ras_n) && $stable(cas_n) && $stable(we_n) && $stable(mem_addr)));

endmodule

bind dram_strobe_seq dseq_chk #(.NGRP(NGRP), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .stretch   (stretch),
  .in_act    (in_act),
  .wr_q      (wr_q),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .mem_addr  (mem_addr),
  .cyc_done  (cyc_done)
);

// File: tb/dram_strobe_seq_tb.sv
`timescale 1ns/1ps
module dram_strobe_seq_tb;

  logic        clk;
  logic        rst_n;
  logic [4:0]  cfg_ras_on, cfg_ras_off, cfg_cas_on, cfg_cas_off, cfg_we_on, cfg_we_off;
  logic [3:0]  cfg_pre_len;
  logic        cfg_fast_en;
  logic [4:0]  cfg_fast_cut;
  logic        req_valid, req_write, req_cpu;
  logic        req_ready;
  logic [12:0] req_row, req_col;
  logic [1:0]  req_sel;
  logic        stretch;
  logic [12:0] mem_addr;
  logic [3:0]  ras_n;
  logic        cas_n, we_n, cyc_done;

  int checks = 0;
  int errors = 0;

  dram_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_ras_on(cfg_ras_on), .cfg_ras_off(cfg_ras_off),
    .cfg_cas_on(cfg_cas_on), .cfg_cas_off(cfg_cas_off),
    .cfg_we_on(cfg_we_on), .cfg_we_off(cfg_we_off),
    .cfg_pre_len(cfg_pre_len), .cfg_fast_en(cfg_fast_en), .cfg_fast_cut(cfg_fast_cut),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_cpu(req_cpu),
    .req_row(req_row), .req_col(req_col), .req_sel(req_sel), .stretch(stretch),
    .mem_addr(mem_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cyc_done(cyc_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string scen, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", req, scen, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int ron, input int roff, input int con, input int coff,
                         input int won, input int woff, input int pre);
    cfg_ras_on = 5'(ron); cfg_ras_off = 5'(roff);
    cfg_cas_on = 5'(con); cfg_cas_off = 5'(coff);
    cfg_we_on  = 5'(won); cfg_we_off  = 5'(woff);
    cfg_pre_len = 4'(pre);
  endtask

  // Drives one request from idle and compares every cycle against the
  // requirement model until the sequencer is ready again.
  task automatic run_access(input string scen, input bit wr, input bit cpu,
                            input logic [12:0] row, input logic [12:0] col,
                            input logic [1:0] sel, input logic [63:0] smask,
                            input bit scramble, output int done_t, output int ready_t);
    int ron, roff, con, coff, won, woff, pe, room, shift, endc, last;
    int ph, k, p;
    bit rl, cl, wl, stl;
    int exp_ras, exp_addr;
    logic [4:0] s_ron, s_roff, s_con, s_coff, s_won, s_woff, s_cut;
    logic [3:0] s_pre;
    logic       s_fast;
    ron = cfg_ras_on; roff = cfg_ras_off; won = cfg_we_on; woff = cfg_we_off;
    con = cfg_cas_on; coff = cfg_cas_off;
    pe = (cfg_pre_len == 0) ? 1 : int'(cfg_pre_len);
    // R8 model: column edges pulled in for processor reads only
    shift = 0;
    if (cfg_fast_en && cpu && !wr) begin
      room  = (con - ron > 1) ? (con - ron - 1) : 0;
      shift = (int'(cfg_fast_cut) < room) ? int'(cfg_fast_cut) : room;
    end
    con  = con - shift;
    coff = (coff >= shift) ? coff - shift : 0;
    last = roff;
    if (coff > last) last = coff;
    if (woff > last) last = woff;
    endc = last + 1;
    s_ron = cfg_ras_on; s_roff = cfg_ras_off; s_con = cfg_cas_on; s_coff = cfg_cas_off;
    s_won = cfg_we_on; s_woff = cfg_we_off; s_cut = cfg_fast_cut; s_pre = cfg_pre_len;
    s_fast = cfg_fast_en;

    chk("R10", scen, int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_cpu = cpu;
    req_row = row; req_col = col; req_sel = sel;
    @(posedge clk);
    @(negedge clk);
    done_t = -1; ready_t = -1;
    ph = 1; k = 1; p = 0;
    if (!scramble) req_valid = 1'b0;
    for (int t = 1; t < 200; t++) begin
      if (cyc_done) done_t = t;
      rl = (ph == 1) && (k >= ron) && (k <= roff);
      cl = (ph == 1) && (k >= con) && (k <= coff);
      wl = (ph == 1) && wr && (k >= won) && (k <= woff);
      exp_ras  = rl ? (4'hF & ~(4'h1 << sel)) : 4'hF;
      exp_addr = (ph != 1) ? 0 : ((k < con) ? int'(row) : int'(col));
      chk("R2", scen, int'(ras_n), exp_ras);
      chk("R2", scen, int'(cas_n), cl ? 0 : 1);
      chk("R6", scen, int'(we_n), wl ? 0 : 1);
      chk("R5", scen, int'(mem_addr), exp_addr);
      chk("R3", scen, int'(cyc_done), ((ph == 1) && (k == endc)) ? 1 : 0);
      chk("R4", scen, int'(req_ready), (ph == 0) ? 1 : 0);
      if (ph == 0) begin
        ready_t = t;
        break;
      end
      stl = (t < 64) ? smask[t] : 1'b0;
      stretch = stl;
      if (scramble && t == 1) begin
        set_cfg(0, 31, 0, 31, 0, 31, 15);
        cfg_fast_en = ~s_fast; cfg_fast_cut = 5'd31;
        req_write = ~wr; req_cpu = ~cpu; req_row = ~row; req_col = ~col; req_sel = sel + 2'd1;
      end
      if (ph == 1) begin
        if (k == endc) begin ph = 2; p = 1; end
        else if (!stl) k++;
      end else if (ph == 2) begin
        if (p >= pe) ph = 0; else p++;
      end
      @(negedge clk);
    end
    stretch = 1'b0;
    req_valid = 1'b0;
    cfg_ras_on = s_ron; cfg_ras_off = s_roff; cfg_cas_on = s_con; cfg_cas_off = s_coff;
    cfg_we_on = s_won; cfg_we_off = s_woff; cfg_fast_cut = s_cut; cfg_pre_len = s_pre;
    cfg_fast_en = s_fast;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "reset held", int'(req_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "reset released", int'(req_ready), 1);
    chk("R1", "reset released", int'(ras_n), 4'hF);
    chk("R1", "reset released", int'({cas_n, we_n}), 3);
    chk("R1", "reset released", int'(mem_addr), 0);
    chk("R1", "reset released", int'(cyc_done), 0);
  endtask

  task automatic t_basic_read;
    int d, r;
    set_cfg(1, 10, 3, 14, 2, 13, 3);
    run_access("R2 basic read", 1'b0, 1'b0, 13'h0ABC, 13'h1234, 2'd0, 64'd0, 1'b0, d, r);
    chk("R3", "basic read done cycle 15", d, 15);
    chk("R4", "basic read ready after 3 precharge", r, 19);
  endtask

  task automatic t_write;
    int d, r;
    set_cfg(1, 10, 3, 14, 2, 13, 3);
    run_access("R6 write", 1'b1, 1'b0, 13'h1555, 13'h0AAA, 2'd2, 64'd0, 1'b0, d, r);
    chk("R3", "write done cycle", d, 15);
  endtask

  task automatic t_back_to_back;
    int d, r;
    set_cfg(2, 6, 4, 8, 3, 7, 2);
    run_access("R4 same group first", 1'b0, 1'b0, 13'h0011, 13'h0022, 2'd1, 64'd0, 1'b0, d, r);
    run_access("R4 same group second", 1'b1, 1'b0, 13'h0033, 13'h0044, 2'd1, 64'd0, 1'b0, d, r);
    chk("R4", "second access ready after precharge", r, 12);
  endtask

  task automatic t_stretch;
    int d, r;
    logic [63:0] m;
    m = '0; m[2] = 1'b1; m[3] = 1'b1; m[8] = 1'b1; m[18] = 1'b1;
    set_cfg(1, 10, 3, 14, 2, 13, 3);
    run_access("R7 stretch", 1'b1, 1'b0, 13'h0F0F, 13'h00F0, 2'd3, m, 1'b0, d, r);
    chk("R7", "stretch delays done by 3, not held at end", d, 18);
  endtask

  task automatic t_fast;
    int d, r;
    set_cfg(1, 10, 3, 14, 2, 13, 3);
    cfg_fast_en = 1'b1; cfg_fast_cut = 5'd1;
    run_access("R8 fast cpu read", 1'b0, 1'b1, 13'h0101, 13'h0202, 2'd0, 64'd0, 1'b0, d, r);
    chk("R8", "fast read done cycle", d, 14);
    set_cfg(1, 10, 6, 14, 2, 5, 3);
    cfg_fast_cut = 5'd10;
    run_access("R8 fast clamp", 1'b0, 1'b1, 13'h0303, 13'h0404, 2'd1, 64'd0, 1'b0, d, r);
    chk("R8", "clamped pull-in done cycle", d, 11);
    run_access("R8 fast ignored on write", 1'b1, 1'b1, 13'h0505, 13'h0606, 2'd2, 64'd0, 1'b0, d, r);
    chk("R8", "cpu write keeps timing", d, 15);
    run_access("R8 fast ignored non-cpu", 1'b0, 1'b0, 13'h0707, 13'h0808, 2'd3, 64'd0, 1'b0, d, r);
    chk("R8", "non-cpu read keeps timing", d, 15);
    cfg_fast_en = 1'b0; cfg_fast_cut = 5'd0;
  endtask

  task automatic t_lanes;
    int d, r;
    set_cfg(1, 4, 2, 5, 1, 5, 1);
    for (int g = 0; g < 4; g++) begin
      run_access("R9 lane select", 1'b0, 1'b0, 13'(g * 3 + 1), 13'(g * 5 + 2), 2'(g), 64'd0, 1'b0, d, r);
      chk("R9", "lane access done", d, 6);
    end
  endtask

  task automatic t_precharge_len;
    int d, r;
    set_cfg(1, 3, 2, 4, 1, 2, 0);
    run_access("R4 precharge zero", 1'b0, 1'b0, 13'h0009, 13'h000A, 2'd0, 64'd0, 1'b0, d, r);
    chk("R4", "zero precharge acts as one", r, 7);
    cfg_pre_len = 4'd15;
    run_access("R4 precharge fifteen", 1'b1, 1'b0, 13'h000B, 13'h000C, 2'd0, 64'd0, 1'b0, d, r);
    chk("R4", "fifteen-cycle precharge", r, 21);
  endtask

  task automatic t_ignore_changes;
    int d, r;
    set_cfg(2, 9, 4, 11, 3, 10, 2);
    run_access("R10 inputs changed mid-access", 1'b0, 1'b0, 13'h1A2B, 13'h0C3D, 2'd2, 64'd0, 1'b1, d, r);
    chk("R10", "captured timing used", d, 12);
  endtask

  initial begin
    rst_n = 1'b0;
    stretch = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cpu = 1'b0;
    req_row = '0; req_col = '0; req_sel = '0;
    cfg_fast_en = 1'b0; cfg_fast_cut = '0;
    set_cfg(1, 10, 3, 14, 2, 13, 3);
    repeat (3) @(negedge clk);
    t_reset();
    t_basic_read();
    t_write();
    t_back_to_back();
    t_stretch();
    t_fast();
    t_lanes();
    t_precharge_len();
    t_ignore_changes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule